// File: doc/BRIEF.md
# One-Time-Programmable Byte Write Sequencer

This block runs the byte-at-a-time write protocol of a small one-time-programmable store. The store holds a 128-byte data field and an 8-byte status field, both kept as internal registers. A host sends a write command, a two-byte start address and one data byte. The block holds the data byte in a one-byte scratchpad and returns a 16-bit check value. It then waits for a commit event. For programmable bytes this event is a program strobe. For the one RAM status byte it is a received FFh byte. After the commit the block returns the stored byte for verification, advances its address and waits for the next data byte.

The host sees three byte-level channels. A receive strobe delivers one byte. A read request is answered one cycle later with one byte. Two single-cycle strobes mark a program pulse and a bus reset. Voltage generation and bit timing stay with the host side. Programmable bytes can only move bits from 1 to 0. The status field also carries per-page write inhibit flags, two fixed bytes, and a RAM byte whose top bit shows whether external supply is present.

Top module: `ebw_write_seq`

## Requirements
- R1: In idle, only command byte 0Fh (data field) and command byte 55h (status field) start a write. Any other command is ignored until a bus reset. A read request in any state other than the two check-value states and the verify state returns FFh.
- R2: The two address bytes arrive low byte first. Address bits 15:7 are forced to zero on capture. For the status field only address bits 2:0 select a byte, and bits 6:3 are not decoded.
- R3: On the first pass the check value is CRC16 with polynomial x16+x15+x2+1. It is shifted LSB first from a cleared generator over four bytes in this order: the command, the masked low address byte, the masked high address byte and the data byte. It is returned as two reads, low byte first, not inverted.
- R4: A program strobe that arrives before both check-value bytes have been read has no effect.
- R5: A commit to a programmable byte stores the bitwise AND of the old value and the scratchpad. Unwritten bytes read FFh.
- R6: The first read after a commit returns the stored byte. The address then increments by one, whether or not the stored byte equals the data sent.
- R7: On every later pass the generator is loaded with the incremented 16-bit address, and the new data byte is then shifted in.
- R8: Bits 3:0 of status byte 0 guard data pages 0 to 3 (32 bytes each, page = address bits 6:5). A 0 in a bit blocks commits to that page.
- R9: Status bytes 5 and 6 read 00h and never change.
- R10: Status byte 7 commits only on a received FFh byte and ignores the program strobe. A commit replaces its bits 6:0 with the scratchpad. Bit 7 always reads the external supply input.
- R11: A bus reset in any state returns the block to idle and discards the scratchpad. A program strobe after the reset changes nothing.
- R12: Every read request is answered with tx_valid_o high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, erases the store |
| bus_reset_i | input | 1 | Single-cycle bus reset strobe |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Host requests one byte |
| prog_pulse_i | input | 1 | Program pulse strobe |
| ext_pwr_i | input | 1 | External supply present |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_data_o | output | 8 | Reply byte |

## Verification
The bench checks the CRC on the first pass and on a follow-on pass. A design that kept shifting instead of loading the incremented address would return a wrong second CRC. A design that skipped the increment after a mismatched verify would also return a wrong CRC. Address masking is checked with out-of-range bytes. The later read-back shows where the byte actually landed, which catches a decoder that uses the ignored status bits. Other tests fire a program strobe between the two CRC reads, on the RAM byte and after a bus reset. A design that acted on any of these would change a byte that a later write-back shows was untouched. Further checks cover commits that must AND rather than overwrite, commits to a page that is write-protected, and the fixed status bytes.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  localparam logic [7:0] CMD_WR_DATA = 8'h0F;
  localparam logic [7:0] CMD_WR_STAT = 8'h55;
  localparam logic [7:0] BYTE_ONES   = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ALO, ST_AHI, ST_DATA, ST_CRC0, ST_CRC1, ST_ARM, ST_VFY, ST_HALT
  } seq_state_e;
endpackage

// File: rtl/ebw_crc16.sv
module ebw_crc16 #(
  parameter logic [15:0] POLY_REV = 16'hA001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        load_i,
  input  logic [15:0] load_val_i,
  input  logic        shift_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [15:0] crc_q;
  logic [15:0] base;

  assign base = clear_i ? 16'h0000 : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (load_i)  crc_q <= load_val_i;
    else if (shift_i) crc_q <= crc_step(base, byte_i);
    else if (clear_i) crc_q <= '0;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ebw_store.sv
module ebw_store #(
  parameter int DATA_BYTES = 128,
  parameter int STAT_BYTES = 8,
  parameter int PAGE_BYTES = 32,
  localparam int DAW   = $clog2(DATA_BYTES),
  localparam int SAW   = $clog2(STAT_BYTES),
  localparam int PAGES = DATA_BYTES / PAGE_BYTES,
  localparam int PGW   = $clog2(PAGES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  input  logic           to_status_i,
  input  logic [DAW-1:0] addr_i,
  input  logic [7:0]     wdata_i,
  input  logic           ext_pwr_i,
  output logic [7:0]     rdata_o
);
  localparam int FIX_A   = 5;
  localparam int FIX_B   = 6;
  localparam int RAM_IDX = STAT_BYTES - 1;

  logic [7:0] data_q [DATA_BYTES];
  logic [7:0] stat_q [STAT_BYTES];

  logic [SAW-1:0] s_idx;
  logic [PGW-1:0] page;
  logic           page_locked;
  logic           s_ram, s_fixed;

  assign s_idx       = addr_i[SAW-1:0];
  assign page        = addr_i[DAW-1 -: PGW];
  assign page_locked = ~stat_q[0][page];
  assign s_ram       = (s_idx == SAW'(RAM_IDX));
  assign s_fixed     = (s_idx == SAW'(FIX_A)) || (s_idx == SAW'(FIX_B));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DATA_BYTES; i++) data_q[i] <= 8'hFF;
      for (int i = 0; i < STAT_BYTES; i++)
        stat_q[i] <= (i == FIX_A || i == FIX_B) ? 8'h00 : 8'hFF;
    end else if (commit_i) begin
      if (to_status_i) begin
        if (s_ram)         stat_q[s_idx] <= {1'b1, wdata_i[6:0]};
        else if (!s_fixed) stat_q[s_idx] <= stat_q[s_idx] & wdata_i;
      end else if (!page_locked) begin
        data_q[addr_i] <= data_q[addr_i] & wdata_i;
      end
    end
  end

  always_comb begin
    if (!to_status_i) rdata_o = data_q[addr_i];
    else if (s_ram)   rdata_o = {ext_pwr_i, stat_q[s_idx][6:0]};
    else              rdata_o = stat_q[s_idx];
  end
endmodule

// File: rtl/ebw_ctrl.sv
module ebw_ctrl
  import ebw_pkg::*;
#(
  parameter int DATA_BYTES = 128,
  parameter int STAT_BYTES = 8,
  localparam int DAW = $clog2(DATA_BYTES),
  localparam int SAW = $clog2(STAT_BYTES),
  localparam logic [15:0] KEEP = 16'(DATA_BYTES - 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_reset_i,
  input  logic           rx_valid_i,
  input  logic [7:0]     rx_data_i,
  input  logic           rd_req_i,
  input  logic           prog_pulse_i,
  input  logic [15:0]    crc_i,
  input  logic [7:0]     rdata_i,
  output logic           crc_clear_o,
  output logic           crc_load_o,
  output logic [15:0]    crc_load_val_o,
  output logic           crc_shift_o,
  output logic [7:0]     crc_byte_o,
  output logic           commit_o,
  output logic           to_status_o,
  output logic [DAW-1:0] mem_addr_o,
  output logic [7:0]     scratch_o,
  output logic           tx_valid_o,
  output logic [7:0]     tx_data_o,
  output seq_state_e     state_o,
  output logic [15:0]    addr_o
);
  seq_state_e  st_q;
  logic [15:0] addr_q;
  logic        is_stat_q;
  logic [7:0]  scratch_q;
  logic        live, cmd_ok, ram_sel;

  assign live    = !bus_reset_i;
  assign cmd_ok  = (rx_data_i == CMD_WR_DATA) || (rx_data_i == CMD_WR_STAT);
  assign ram_sel = is_stat_q && (addr_q[SAW-1:0] == SAW'(STAT_BYTES - 1));

  always_comb begin
    crc_clear_o    = live && st_q == ST_IDLE && rx_valid_i && cmd_ok;
    crc_shift_o    = live && rx_valid_i &&
                     ((st_q == ST_IDLE && cmd_ok) || st_q == ST_ALO ||
                      st_q == ST_AHI || st_q == ST_DATA);
    crc_load_o     = live && st_q == ST_VFY && rd_req_i;
    crc_load_val_o = addr_q + 16'd1;
    case (st_q)
      ST_ALO:  crc_byte_o = rx_data_i & KEEP[7:0];
      ST_AHI:  crc_byte_o = rx_data_i & KEEP[15:8];
      default: crc_byte_o = rx_data_i;
    endcase
    // RAM byte commits on an all-ones byte, everything else on the strobe
    commit_o = live && st_q == ST_ARM &&
               (ram_sel ? (rx_valid_i && rx_data_i == BYTE_ONES) : prog_pulse_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      is_stat_q <= 1'b0;
      scratch_q <= BYTE_ONES;
    end else if (bus_reset_i) begin
      st_q      <= ST_IDLE;
      scratch_q <= BYTE_ONES;
    end else begin
      case (st_q)
        ST_IDLE: if (rx_valid_i) begin
          st_q      <= cmd_ok ? ST_ALO : ST_HALT;
          is_stat_q <= (rx_data_i == CMD_WR_STAT);
        end
        ST_ALO: if (rx_valid_i) begin
          addr_q[7:0] <= rx_data_i & KEEP[7:0];
          st_q        <= ST_AHI;
        end
        ST_AHI: if (rx_valid_i) begin
          addr_q[15:8] <= rx_data_i & KEEP[15:8];
          st_q         <= ST_DATA;
        end
        ST_DATA: if (rx_valid_i) begin
          scratch_q <= rx_data_i;
          st_q      <= ST_CRC0;
        end
        ST_CRC0: if (rd_req_i) st_q <= ST_CRC1;
        ST_CRC1: if (rd_req_i) st_q <= ST_ARM;
        ST_ARM:  if (commit_o) st_q <= ST_VFY;
        ST_VFY: if (rd_req_i) begin
          addr_q <= addr_q + 16'd1;
          st_q   <= ST_DATA;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= BYTE_ONES;
    end else begin
      tx_valid_o <= rd_req_i;
      if (rd_req_i) begin
        case (st_q)
          ST_CRC0: tx_data_o <= crc_i[7:0];
          ST_CRC1: tx_data_o <= crc_i[15:8];
          ST_VFY:  tx_data_o <= rdata_i;
          default: tx_data_o <= BYTE_ONES;
        endcase
      end
    end
  end

  assign to_status_o = is_stat_q;
  assign mem_addr_o  = addr_q[DAW-1:0];
  assign scratch_o   = scratch_q;
  assign state_o     = st_q;
  assign addr_o      = addr_q;
endmodule

// File: rtl/ebw_write_seq.sv
module ebw_write_seq
  import ebw_pkg::*;
#(
  parameter int DATA_BYTES = 128,
  parameter int STAT_BYTES = 8,
  parameter int PAGE_BYTES = 32,
  localparam int DAW = $clog2(DATA_BYTES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_reset_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rd_req_i,
  input  logic       prog_pulse_i,
  input  logic       ext_pwr_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o
);
  logic           crc_clear, crc_load, crc_shift;
  logic [15:0]    crc_load_val, crc;
  logic [7:0]     crc_byte, rdata, scratch;
  logic           commit, to_status;
  logic [DAW-1:0] mem_addr;
  seq_state_e     st;
  logic [15:0]    addr;

  ebw_ctrl #(.DATA_BYTES(DATA_BYTES), .STAT_BYTES(STAT_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .bus_reset_i, .rx_valid_i, .rx_data_i, .rd_req_i, .prog_pulse_i,
    .crc_i(crc), .rdata_i(rdata),
    .crc_clear_o(crc_clear), .crc_load_o(crc_load), .crc_load_val_o(crc_load_val),
    .crc_shift_o(crc_shift), .crc_byte_o(crc_byte),
    .commit_o(commit), .to_status_o(to_status), .mem_addr_o(mem_addr),
    .scratch_o(scratch), .tx_valid_o, .tx_data_o, .state_o(st), .addr_o(addr)
  );

  ebw_crc16 u_crc (
    .clk_i, .rst_ni, .clear_i(crc_clear), .load_i(crc_load), .load_val_i(crc_load_val),
    .shift_i(crc_shift), .byte_i(crc_byte), .crc_o(crc)
  );

  ebw_store #(.DATA_BYTES(DATA_BYTES), .STAT_BYTES(STAT_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk_i, .rst_ni, .commit_i(commit), .to_status_i(to_status), .addr_i(mem_addr),
    .wdata_i(scratch), .ext_pwr_i, .rdata_o(rdata)
  );
endmodule

// File: rtl/ebw_write_seq_chk.sv
module ebw_write_seq_chk
  import ebw_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_reset_i,
  input logic        rx_valid_i,
  input logic [7:0]  rx_data_i,
  input logic        rd_req_i,
  input logic        prog_pulse_i,
  input logic        tx_valid_o,
  input logic [7:0]  tx_data_o,
  input seq_state_e  st,
  input logic [15:0] addr,
  input logic        commit
);
  a_r12_reply_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> tx_valid_o);

  a_r12_no_stray_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !tx_valid_o);

  a_r11_reset_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> st == ST_IDLE);

  a_r4_no_early_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CRC0 || st == ST_CRC1) |-> !commit);

  a_r10_commit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (prog_pulse_i || (rx_valid_i && rx_data_i == BYTE_ONES)));

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_VFY && rd_req_i && !bus_reset_i) |=> addr == $past(addr) + 16'd1);

  a_r1_idle_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && rd_req_i) |=> tx_data_o == BYTE_ONES);
endmodule

bind ebw_write_seq ebw_write_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i), .rx_valid_i(rx_valid_i),
  .rx_data_i(rx_data_i), .rd_req_i(rd_req_i), .prog_pulse_i(prog_pulse_i),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .st(st), .addr(addr), .commit(commit)
);

// File: tb/ebw_write_seq_test.sv
module ebw_write_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_reset_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       rd_req_i = 1'b0;
  logic       prog_pulse_i = 1'b0;
  logic       ext_pwr_i = 1'b1;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  ebw_write_seq uut (.*);

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i); rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk_i); rx_valid_i = 1'b0;
  endtask

  task automatic fetch(output logic [7:0] b);
    @(negedge clk_i); rd_req_i = 1'b1;
    @(negedge clk_i); rd_req_i = 1'b0;
    b = tx_data_o;
    if (tx_valid_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R12: got tx_valid %b expected 1", tx_valid_o);
    end
  endtask

  task automatic prog();
    @(negedge clk_i); prog_pulse_i = 1'b1;
    @(negedge clk_i); prog_pulse_i = 1'b0;
  endtask

  task automatic bus_rst();
    @(negedge clk_i); bus_reset_i = 1'b1;
    @(negedge clk_i); bus_reset_i = 1'b0;
  endtask

  task automatic read_crc(input string tag, input logic [15:0] exp);
    logic [7:0] b;
    fetch(b); check({tag, " crc lo"}, b, exp[7:0]);
    fetch(b); check({tag, " crc hi"}, b, exp[15:8]);
  endtask

  // first pass: command, address, data, then CRC check against the R2-masked address
  task automatic head(input string tag, input logic [7:0] cmd, input logic [7:0] lo,
                      input logic [7:0] hi, input logic [7:0] d);
    logic [15:0] c = 16'h0000;
    c = crc_upd(c, cmd); c = crc_upd(c, lo & 8'h7F); c = crc_upd(c, 8'h00); c = crc_upd(c, d);
    send(cmd); send(lo); send(hi); send(d);
    read_crc(tag, c);
  endtask

  task automatic next_pass(input string tag, input logic [15:0] a, input logic [7:0] d);
    send(d);
    read_crc(tag, crc_upd(a, d));
  endtask

  task automatic verify(input string tag, input logic [7:0] exp);
    logic [7:0] b;
    fetch(b); check(tag, b, exp);
  endtask

  task automatic t_reset();
    verify("R1 idle read after reset", 8'hFF);
  endtask

  task automatic t_first_and_next();
    head("R3 first pass", 8'h0F, 8'h23, 8'h00, 8'h5A);
    prog(); verify("R5 commit erased byte", 8'h5A);
    next_pass("R7 preloaded pass", 16'h0024, 8'h3C);
    prog(); verify("R6 verify next byte", 8'h3C);
    bus_rst();
  endtask

  task automatic t_and();
    head("R3 and pass", 8'h0F, 8'h23, 8'h00, 8'hF0);
    prog(); verify("R5 bitwise and", 8'h50);
    bus_rst();
  endtask

  task automatic t_mask();
    head("R2 masked crc", 8'h0F, 8'hA5, 8'h12, 8'h81);
    prog(); verify("R2 masked commit", 8'h81);
    bus_rst();
    head("R2 readback", 8'h0F, 8'h25, 8'h00, 8'hFF);
    prog(); verify("R2 landed at 25h", 8'h81);
    bus_rst();
  endtask

  task automatic t_early_prog();
    logic [15:0] c = 16'h0000;
    logic [7:0] b;
    c = crc_upd(c, 8'h0F); c = crc_upd(c, 8'h40); c = crc_upd(c, 8'h00); c = crc_upd(c, 8'h00);
    send(8'h0F); send(8'h40); send(8'h00); send(8'h00);
    fetch(b); check("R4 crc lo", b, c[7:0]);
    prog();
    fetch(b); check("R4 crc hi after early strobe", b, c[15:8]);
    bus_rst();
    head("R4 readback", 8'h0F, 8'h40, 8'h00, 8'hFF);
    prog(); verify("R4 byte untouched", 8'hFF);
    bus_rst();
  endtask

  task automatic t_protect();
    head("R8 set guard", 8'h55, 8'h00, 8'h00, 8'hFD);
    prog(); verify("R8 guard byte", 8'hFD);
    bus_rst();
    head("R8 locked page", 8'h0F, 8'h30, 8'h00, 8'h00);
    prog(); verify("R8 locked byte unchanged", 8'hFF);
    next_pass("R6 increment after mismatch", 16'h0031, 8'h11);
    prog(); verify("R8 locked next byte", 8'hFF);
    bus_rst();
    head("R8 open page", 8'h0F, 8'h05, 8'h00, 8'h0F);
    prog(); verify("R8 page 0 writable", 8'h0F);
    bus_rst();
  endtask

  task automatic t_fixed();
    head("R9 byte 5", 8'h55, 8'h05, 8'h00, 8'hFF);
    prog(); verify("R9 byte 5 reads 00", 8'h00);
    next_pass("R7 status pass", 16'h0006, 8'hFF);
    prog(); verify("R9 byte 6 reads 00", 8'h00);
    bus_rst();
  endtask

  task automatic t_ram();
    ext_pwr_i = 1'b1;
    head("R10 ram", 8'h55, 8'h07, 8'h00, 8'h15);
    prog();
    verify("R10 strobe ignored on ram", 8'hFF);
    send(8'hFF);
    verify("R10 ram commit", 8'h95);
    bus_rst();
    ext_pwr_i = 1'b0;
    head("R10 ram rewrite", 8'h55, 8'h07, 8'h00, 8'h60);
    send(8'hFF);
    verify("R10 ram overwrite", 8'h60);
    bus_rst();
    ext_pwr_i = 1'b1;
    head("R2 status high bits", 8'h55, 8'h7F, 8'h00, 8'h22);
    send(8'hFF);
    verify("R2 bits 6:3 not decoded", 8'hA2);
    bus_rst();
  endtask

  task automatic t_bus_reset();
    send(8'h0F); send(8'h50); send(8'h00); send(8'h00);
    bus_rst();
    prog();
    head("R11 readback", 8'h0F, 8'h50, 8'h00, 8'hFF);
    prog(); verify("R11 scratch discarded", 8'hFF);
    bus_rst();
  endtask

  task automatic t_bad_cmd();
    send(8'hF0); send(8'h10); send(8'h00);
    prog();
    verify("R1 unknown command", 8'hFF);
    send(8'hFF);
    verify("R1 still ignored", 8'hFF);
    bus_rst();
    head("R1 readback", 8'h0F, 8'h10, 8'h00, 8'hFF);
    prog(); verify("R1 memory untouched", 8'hFF);
    bus_rst();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_first_and_next();
    t_and();
    t_mask();
    t_early_prog();
    t_protect();
    t_fixed();
    t_ram();
    t_bus_reset();
    t_bad_cmd();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule